// File: doc/BRIEF.md
# Color Palette Host Access Controller

This block is the processor-facing access logic of a color lookup table with 256 entries of 24 bits and four overlay color registers of 24 bits each. The host reaches it through an 8-bit data bus, split here into an input byte, an output byte and an output enable. It selects one of three targets with a 2-bit select field: the address register, the palette, or the overlay bank. A 24-bit color is always moved as three byte transfers in a fixed order: red, green, blue.

A 2-bit phase counter steps through the three color bytes, and every color byte access advances it. On writes, the red and green bytes wait in staging registers. The blue byte commits the full 24-bit word to the addressed location in one step. After the blue byte, whether it was read or written, the address moves to the next entry. Overlay accesses follow the same sequence. Their address also keeps counting past the last overlay register.

A separate pixel-side port takes an 8-bit index and returns the 24-bit palette entry one clock later. A host access takes exactly one clock cycle: the cycle in which `cs_i` is high at the rising edge.

Top module: `clut_host_ctrl`

## Requirements
- R1: After reset the address register is 0 and the phase counter points at red. A first address read returns 0x00, and a first three-byte palette write lands in entry 0.
- R2: Select value 2'b00 targets the address register. A write loads the address from `data_i`. A read drives the address on `data_o`. Both the write and the read return the phase counter to red.
- R3: Every color byte access (select 2'b01 or 2'b11, read or write) advances the phase red→green→blue→red. Reads return the red byte (bits 23:16), then the green byte (bits 15:8), then the blue byte (bits 7:0) of the addressed entry.
- R4: A palette write of the red or green byte leaves the palette entry unchanged. The blue write stores {red, green, blue} into the entry at the current address in a single step.
- R5: The address increments by one after each blue byte access, for reads and writes alike, and wraps from 0xFF to 0x00.
- R6: Select value 2'b11 targets four 24-bit overlay registers at addresses 0 to 3. They use the same staging, commit-on-blue and read order as the palette, and they never change the palette.
- R7: Overlay accesses at address 4 or above leave the overlay registers unchanged on writes and return 0x00 on reads. The phase and address still advance, so blue on overlay 3 moves the address to 4.
- R8: Select value 2'b10 is reserved. Writes to it change nothing, reads return 0x00, and the address and phase hold.
- R9: `data_oe_o` is high only in a cycle with `cs_i` high and `rd_wr_i` high (read).
- R10: `pix_rgb_o` shows the palette entry indexed by `pix_idx_i` at the previous rising edge (one clock of latency).
- R11: With `cs_i` low, no state changes regardless of the other host inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host access strobe, one access per high cycle |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| sel_i | input | 2 | Target: 00 address, 01 palette, 10 reserved, 11 overlay |
| data_i | input | 8 | Host write byte |
| data_o | output | 8 | Host read byte |
| data_oe_o | output | 1 | Drive enable for the host data bus |
| pix_idx_i | input | 8 | Pixel-side palette index |
| pix_rgb_o | output | 24 | Pixel-side palette entry, one cycle after the index |

## Verification
The bench watches the palette entry through the pixel port between the green and blue writes. A design that commits early would show a half-updated color there. It reloads the address register halfway through a color, both by writing it and by reading it. A counter that fails to clear would then shift every later byte by one lane. It crosses the 0xFF boundary and the overlay 3 to 4 boundary. A design that wraps the overlay address to 0 would rewrite overlay 0. One that suppresses advancing out of range would leave the address stuck at 4. It also places reserved-select accesses and cycles with `cs_i` low in the middle of a color sequence. Any phase or address disturbance from these would corrupt the committed word that follows.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    TGT_ADDR = 2'b00,
    TGT_PAL  = 2'b01,
    TGT_RSVD = 2'b10,
    TGT_OVL  = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_e;

  function automatic phase_e next_phase(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

endpackage

// File: rtl/clut_addr_seq.sv
module clut_addr_seq
  import clut_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_ld_i,
  input  logic          phase_clr_i,
  input  logic          step_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] addr_o,
  output phase_e        phase_o
);

  logic [AW-1:0] addr_q;
  phase_e        phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      phase_q <= PH_RED;
    end else if (addr_ld_i) begin
      addr_q  <= ld_val_i;
      phase_q <= PH_RED;
    end else if (phase_clr_i) begin
      phase_q <= PH_RED;
    end else if (step_i) begin
      phase_q <= next_phase(phase_q);
      // blue closes the entry: move to the next one, natural wrap
      if (phase_q == PH_BLU) addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o  = addr_q;
  assign phase_o = phase_q;

  // R2
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ld_i |=> (addr_q == $past(ld_val_i)) && (phase_q == PH_RED));

  // R2
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_clr_i && !addr_ld_i) |=> (phase_q == PH_RED) && $stable(addr_q));

  // R5
  blue_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !addr_ld_i && !phase_clr_i && phase_q == PH_BLU)
      |=> (phase_q == PH_RED) && (addr_q == $past(addr_q) + AW'(1)));

  // R3
  mid_color_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !addr_ld_i && !phase_clr_i && phase_q != PH_BLU)
      |=> $stable(addr_q) && (phase_q != $past(phase_q)));

  // R8, R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_ld_i || phase_clr_i || step_i) |=> $stable(addr_q) && $stable(phase_q));

endmodule

// File: rtl/clut_color_store.sv
module clut_color_store
  import clut_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned OVL_N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           pal_sel_i,
  input  logic           ovl_sel_i,
  input  phase_e         phase_i,
  input  logic [DW-1:0]  addr_i,
  input  logic [DW-1:0]  data_i,
  input  logic [DW-1:0]  pix_idx_i,
  output logic [DW-1:0]  rd_byte_o,
  output logic [3*DW-1:0] pix_rgb_o
);

  localparam int unsigned CW     = 3 * DW;
  localparam int unsigned DEPTH  = 2 ** DW;
  localparam int unsigned OVL_AW = (OVL_N > 1) ? $clog2(OVL_N) : 1;
  localparam logic [DW-1:0] OVL_LIM = DW'(OVL_N);

  logic [DW-1:0]             red_q, grn_q;
  logic [CW-1:0]             pal_mem [DEPTH];
  logic [OVL_N-1:0][CW-1:0]  ovl_q;
  logic [CW-1:0]             pix_q;
  logic [CW-1:0]             commit_word;
  logic [CW-1:0]             src_word;
  logic                      color_wr, commit, ovl_hit;
  logic [OVL_AW-1:0]         ovl_idx;

  assign color_wr    = wr_i && (pal_sel_i || ovl_sel_i);
  assign commit      = color_wr && (phase_i == PH_BLU);
  assign commit_word = {red_q, grn_q, data_i};
  assign ovl_hit     = addr_i < OVL_LIM;
  assign ovl_idx     = addr_i[OVL_AW-1:0];

  // staging for the first two bytes of a color
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_q <= '0;
      grn_q <= '0;
    end else if (color_wr) begin
      if (phase_i == PH_RED) red_q <= data_i;
      if (phase_i == PH_GRN) grn_q <= data_i;
    end
  end

  // palette array: no reset, single write port, registered pixel read
  always_ff @(posedge clk_i) begin
    if (commit && pal_sel_i) pal_mem[addr_i] <= commit_word;
    pix_q <= pal_mem[pix_idx_i];
  end

  for (genvar g = 0; g < OVL_N; g++) begin : g_ovl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovl_q[g] <= '0;
      end else if (commit && ovl_sel_i && ovl_hit && ovl_idx == OVL_AW'(g)) begin
        ovl_q[g] <= commit_word;
      end
    end
  end

  always_comb begin
    if (pal_sel_i)                src_word = pal_mem[addr_i];
    else if (ovl_sel_i && ovl_hit) src_word = ovl_q[ovl_idx];
    else                          src_word = '0;
  end

  always_comb begin
    case (phase_i)
      PH_RED:  rd_byte_o = src_word[CW-1 -: DW];
      PH_GRN:  rd_byte_o = src_word[2*DW-1 -: DW];
      PH_BLU:  rd_byte_o = src_word[DW-1:0];
      default: rd_byte_o = '0;
    endcase
  end

  assign pix_rgb_o = pix_q;

  // R7
  ovl_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ovl_sel_i && !ovl_hit) |=> $stable(ovl_q));

  // R6
  ovl_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && ovl_sel_i) |=> $stable(ovl_q));

endmodule

// File: rtl/clut_host_ctrl.sv
module clut_host_ctrl
  import clut_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVL_N  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                rd_wr_i,
  input  logic [1:0]          sel_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe_o,
  input  logic [DATA_W-1:0]   pix_idx_i,
  output logic [3*DATA_W-1:0] pix_rgb_o
);

  tgt_e              tgt;
  phase_e            phase;
  logic [DATA_W-1:0] addr;
  logic [DATA_W-1:0] color_byte;
  logic              is_rd, is_wr, color_tgt;

  assign tgt       = tgt_e'(sel_i);
  assign is_rd     = cs_i && rd_wr_i;
  assign is_wr     = cs_i && !rd_wr_i;
  assign color_tgt = (tgt == TGT_PAL) || (tgt == TGT_OVL);

  clut_addr_seq #(.AW(DATA_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_ld_i   (is_wr && tgt == TGT_ADDR),
    .phase_clr_i (is_rd && tgt == TGT_ADDR),
    .step_i      (cs_i && color_tgt),
    .ld_val_i    (data_i),
    .addr_o      (addr),
    .phase_o     (phase)
  );

  clut_color_store #(.DW(DATA_W), .OVL_N(OVL_N)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (is_wr),
    .pal_sel_i (tgt == TGT_PAL),
    .ovl_sel_i (tgt == TGT_OVL),
    .phase_i   (phase),
    .addr_i    (addr),
    .data_i    (data_i),
    .pix_idx_i (pix_idx_i),
    .rd_byte_o (color_byte),
    .pix_rgb_o (pix_rgb_o)
  );

  always_comb begin
    data_o = '0;
    if (is_rd) begin
      case (tgt)
        TGT_ADDR: data_o = addr;
        TGT_PAL,
        TGT_OVL:  data_o = color_byte;
        default:  data_o = '0;
      endcase
    end
  end

  assign data_oe_o = is_rd;

  // R9
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

endmodule

// File: tb/test_clut_host_ctrl.sv
module test_clut_host_ctrl;

  localparam logic [1:0] S_ADR = 2'b00, S_PAL = 2'b01, S_RSV = 2'b10, S_OVL = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rw = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [7:0]  din = '0, dout;
  logic        oe;
  logic [7:0]  pidx = '0;
  logic [23:0] prgb;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  clut_host_ctrl i_clut_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_wr_i(rw), .sel_i(sel),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .pix_idx_i(pidx), .pix_rgb_o(prgb)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic r, input logic [1:0] s, input logic [7:0] d,
                     output logic [7:0] q, output logic o);
    @(negedge clk);
    cs = 1'b1; rw = r; sel = s; din = d;
    #1; q = dout; o = oe;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    logic [7:0] q; logic o;
    acc(1'b0, s, d, q, o);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] q);
    logic o;
    acc(1'b1, s, 8'h00, q, o);
  endtask

  task automatic wr_rgb(input logic [1:0] s, input logic [23:0] c);
    wr(s, c[23:16]); wr(s, c[15:8]); wr(s, c[7:0]);
  endtask

  task automatic pix_get(input logic [7:0] idx, output logic [23:0] v);
    @(negedge clk);
    cs = 1'b0; pidx = idx;
    @(posedge clk); #1;
    v = prgb;
  endtask

  task automatic t_reset();
    logic [7:0] q; logic o; logic [23:0] v;
    idle(); #1;
    chk("R9 oe idle", oe, 1'b0);
    acc(1'b1, S_ADR, 8'h00, q, o);
    chk("R1 addr after reset", q, 8'h00);
    chk("R9 oe on read", o, 1'b1);
    acc(1'b0, S_ADR, 8'h00, q, o);
    chk("R9 oe on write", o, 1'b0);
    wr_rgb(S_PAL, 24'hDEAD01);
    pix_get(8'h00, v);
    chk("R1 first entry", v, 24'hDEAD01);
  endtask

  task automatic t_pal_rw();
    logic [7:0] q;
    wr(S_ADR, 8'h10);
    wr_rgb(S_PAL, 24'h112233);
    wr_rgb(S_PAL, 24'h445566);
    wr(S_ADR, 8'h10);
    rd(S_PAL, q); chk("R3 red", q, 8'h11);
    rd(S_PAL, q); chk("R3 green", q, 8'h22);
    rd(S_PAL, q); chk("R3 blue", q, 8'h33);
    rd(S_PAL, q); chk("R3 next red", q, 8'h44);
    rd(S_ADR, q); chk("R5 addr mid entry", q, 8'h11);
  endtask

  task automatic t_commit();
    logic [23:0] v;
    wr(S_ADR, 8'h05);
    wr_rgb(S_PAL, 24'hAABBCC);
    wr(S_ADR, 8'h05);
    wr(S_PAL, 8'h01); wr(S_PAL, 8'h02);
    pix_get(8'h05, v);
    chk("R4 no commit before blue", v, 24'hAABBCC);
    wr(S_PAL, 8'h03);
    pix_get(8'h05, v);
    chk("R4 commit on blue", v, 24'h010203);
  endtask

  task automatic t_phase_clear();
    logic [7:0] q; logic [23:0] v;
    wr(S_ADR, 8'h20);
    wr(S_PAL, 8'h99);
    wr(S_ADR, 8'h20);
    wr_rgb(S_PAL, 24'h556677);
    pix_get(8'h20, v);
    chk("R2 addr write clears phase", v, 24'h556677);
    wr(S_ADR, 8'h05);
    rd(S_PAL, q);
    rd(S_ADR, q); chk("R2 addr readback", q, 8'h05);
    rd(S_PAL, q); chk("R2 addr read clears phase", q, 8'h01);
  endtask

  task automatic t_wrap();
    logic [7:0] q; logic [23:0] v;
    wr(S_ADR, 8'hFF);
    wr_rgb(S_PAL, 24'hC0FFEE);
    rd(S_ADR, q); chk("R5 wrap to zero", q, 8'h00);
    pix_get(8'hFF, v);
    chk("R5 last entry", v, 24'hC0FFEE);
    wr(S_ADR, 8'hFF);
    rd(S_PAL, q); rd(S_PAL, q); rd(S_PAL, q);
    chk("R5 last blue read", q, 8'hEE);
    rd(S_ADR, q); chk("R5 read wrap", q, 8'h00);
  endtask

  task automatic t_overlay();
    logic [7:0] q; logic [23:0] v;
    wr(S_ADR, 8'h00);
    for (int k = 0; k < 4; k++) wr_rgb(S_OVL, {8'h10 + 8'(k), 8'h20 + 8'(k), 8'h30 + 8'(k)});
    rd(S_ADR, q); chk("R7 past last overlay", q, 8'h04);
    wr(S_ADR, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rd(S_OVL, q); chk("R6 ovl red", q, 8'h10 + 8'(k));
      rd(S_OVL, q); chk("R6 ovl green", q, 8'h20 + 8'(k));
      rd(S_OVL, q); chk("R6 ovl blue", q, 8'h30 + 8'(k));
    end
    pix_get(8'h00, v);
    chk("R6 palette untouched", v, 24'hDEAD01);
  endtask

  task automatic t_ovl_oob();
    logic [7:0] q;
    wr(S_ADR, 8'h04);
    wr_rgb(S_OVL, 24'hFFFFFF);
    rd(S_ADR, q); chk("R7 oob write advances", q, 8'h05);
    wr(S_ADR, 8'h04);
    for (int k = 0; k < 3; k++) begin
      rd(S_OVL, q); chk("R7 oob read zero", q, 8'h00);
    end
    rd(S_ADR, q); chk("R7 oob read advances", q, 8'h05);
    wr(S_ADR, 8'h03);
    rd(S_OVL, q); chk("R7 ovl3 red kept", q, 8'h13);
    rd(S_OVL, q); chk("R7 ovl3 green kept", q, 8'h23);
    rd(S_OVL, q); chk("R7 ovl3 blue kept", q, 8'h33);
    wr(S_ADR, 8'h00);
    rd(S_OVL, q); chk("R7 ovl0 kept", q, 8'h10);
  endtask

  task automatic t_reserved();
    logic [7:0] q; logic [23:0] v;
    wr(S_ADR, 8'h30);
    wr(S_PAL, 8'h9A);
    wr(S_RSV, 8'h77);
    rd(S_RSV, q); chk("R8 reserved read zero", q, 8'h00);
    wr(S_PAL, 8'hBC);
    wr(S_PAL, 8'hDE);
    pix_get(8'h30, v);
    chk("R8 sequence undisturbed", v, 24'h9ABCDE);
    rd(S_ADR, q); chk("R8 addr", q, 8'h31);
  endtask

  task automatic t_cs_low();
    logic [7:0] q; logic [23:0] v;
    wr(S_ADR, 8'h40);
    wr(S_PAL, 8'h12);
    @(negedge clk); cs = 1'b0; rw = 1'b0; sel = S_ADR; din = 8'h99;
    @(negedge clk); sel = S_PAL; din = 8'h66;
    #1; chk("R11 oe low", oe, 1'b0);
    wr(S_PAL, 8'h34); wr(S_PAL, 8'h56);
    pix_get(8'h40, v);
    chk("R11 no effect", v, 24'h123456);
  endtask

  task automatic t_pix_latency();
    logic [23:0] v;
    pix_get(8'h05, v);
    chk("R10 pixel entry", v, 24'h010203);
    @(negedge clk); pidx = 8'h20;
    #1; chk("R10 old value before edge", prgb, 24'h010203);
    @(posedge clk); #1;
    chk("R10 new value after edge", prgb, 24'h556677);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pal_rw();
    t_commit();
    t_phase_clear();
    t_wrap();
    t_overlay();
    t_ovl_oob();
    t_reserved();
    t_cs_low();
    t_pix_latency();
    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule